// File: doc/BRIEF.md
# Multi-Port Event Interrupt Aggregator

This block gathers status-change notifications from a group of PHY ports and reduces them to one shared active-low interrupt line. Each port holds a sticky status register with five event bits, set by one-cycle pulses from the event detectors. Each port also has a mask register that picks which of those bits may raise an interrupt.

The enabled pending bits of each port are ORed into a single request for that port. The requests of all ports are ORed together and then gated by a global enable. A force control drives the line active no matter what the event state is.

Software finds the cause by reading a port's status through a small register-read port. The read returns the current bits and clears them. A new event that lands in the read cycle is kept. The mask registers are loaded through a separate write strobe addressed by port number.

Top module: `phy_irq_aggregator`

## Requirements
- R1: A one-cycle pulse on `evt_pulse[p*5+e]` sets status bit e of port p at the next clock edge. The bit positions are: 0 auto-negotiation done, 1 speed change, 2 duplex change, 3 link change, 4 isolate change.
- R2: A status bit stays set until its port is read. Later cycles without a read do not clear it.
- R3: `rd_data` always shows the status of port `rd_port`. A cycle with `rd_en` high clears that port's status at the clock edge. A bit whose event pulse arrives in the same cycle as the read remains set.
- R4: Reading one port leaves the status of every other port unchanged.
- R5: After reset, every mask register is all zeros, so events alone raise no interrupt even with the global enable set.
- R6: A port requests an interrupt only when at least one status bit is set and its matching mask bit is 1.
- R7: A request from any single port, at any port number, drives the interrupt line.
- R8: With `glob_en` low and `force_irq` low, `irq_n` stays high whatever the requests.
- R9: With `force_irq` high, `irq_n` goes low at the next clock edge, whatever the events, masks and global enable.
- R10: `irq_n` is registered and resets high. It falls one clock edge after the enabled status bit is set, which is two edges after the pulse. It rises one edge after the read that cleared the last enabled bit.
- R11: A mask write (`en_we` high) loads `en_wdata` into the mask of port `en_port` only. The masks of the other ports keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_pulse | input | 40 | Event pulses, five per port, port p at bits p*5+4..p*5 |
| en_we | input | 1 | Mask register write strobe |
| en_port | input | 3 | Port addressed by the mask write |
| en_wdata | input | 5 | New mask value |
| glob_en | input | 1 | Global interrupt enable |
| force_irq | input | 1 | Forces the interrupt line active |
| rd_en | input | 1 | Status read strobe; clears the addressed status |
| rd_port | input | 3 | Port whose status is shown and read |
| rd_data | output | 5 | Status of the addressed port |
| irq_n | output | 1 | Shared interrupt, active low, registered |

## Verification
A lost or stuck status bit shows up in `rd_data` on the very next read of that port. A wrong clear shows up as a read returning zero where a bit was expected, or as a bit surviving a read. A mask that is wrong, or a fault in the reduction across ports, moves the falling or rising edge of `irq_n`. Because that edge follows the status register by exactly one clock, any such error appears at the port within two cycles of the pulse or read that exposes it.

// File: rtl/phy_irq_pkg.sv
// Package: shared constants for the PHY event interrupt aggregator.
// Assumes: five event kinds per port, in the fixed bit order listed below.
package phy_irq_pkg;
    localparam int EVT_W = 5;

    typedef enum int {
        EV_ANEG_DONE = 0,
        EV_SPEED     = 1,
        EV_DUPLEX    = 2,
        EV_LINK      = 3,
        EV_ISOLATE   = 4
    } evt_idx_e;
endpackage

// File: rtl/port_event_regs.sv
// Module: per-port sticky event status, event mask and port request.
// Assumes: event pulses last one cycle; rd_clr is high for one cycle per read.
module port_event_regs #(
    parameter int EVT_W = phy_irq_pkg::EVT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt,
    input  logic             rd_clr,
    input  logic             en_we,
    input  logic [EVT_W-1:0] en_wdata,
    output logic [EVT_W-1:0] status,
    output logic             req
);
    logic [EVT_W-1:0] mask_q;

    // Sticky status: a read clears the bits, a same-cycle event survives the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else
            status <= (rd_clr ? '0 : status) | evt;
    end

    // Mask register: loaded by an addressed write, all zeros after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (en_we)
            mask_q <= en_wdata;
    end

    // Port request: any pending bit whose mask bit is set.
    always_comb req = |(status & mask_q);

    assert_evt_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(evt)) == $past(evt)));

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((status & $past(status)) == $past(status)));

    assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && evt == '0) |=> (status == '0));

    assert_mask_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !req);
endmodule

// File: rtl/irq_combine.sv
// Module: merges the per-port requests, applies the global enable and force,
// and registers the active-low interrupt line.
// Assumes: requests come from flops in the same clock domain.
module irq_combine #(
    parameter int NUM_PORTS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] port_req,
    input  logic                 glob_en,
    input  logic                 force_irq,
    output logic                 irq_n
);
    logic any_req;

    // Reduction across all ports.
    always_comb any_req = |port_req;

    // Registered line, released after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_n <= 1'b1;
        else
            irq_n <= !((glob_en && any_req) || force_irq);
    end

    assert_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
        force_irq |=> !irq_n);

    assert_gate_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && !force_irq) |=> irq_n);

    assert_registered_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_en && any_req) |=> !irq_n);
endmodule

// File: rtl/phy_irq_aggregator.sv
// Module: top of the multi-port event interrupt aggregator.
// Assumes: one clock domain; evt_pulse is grouped by port, EVT_W bits each.
module phy_irq_aggregator #(
    parameter int NUM_PORTS = 8,
    parameter int EVT_W     = phy_irq_pkg::EVT_W,
    localparam int PORT_AW  = $clog2(NUM_PORTS),
    localparam int FLAT_W   = NUM_PORTS * EVT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FLAT_W-1:0]  evt_pulse,
    input  logic               en_we,
    input  logic [PORT_AW-1:0] en_port,
    input  logic [EVT_W-1:0]   en_wdata,
    input  logic               glob_en,
    input  logic               force_irq,
    input  logic               rd_en,
    input  logic [PORT_AW-1:0] rd_port,
    output logic [EVT_W-1:0]   rd_data,
    output logic               irq_n
);
    logic [EVT_W-1:0]     status_arr [NUM_PORTS];
    logic [NUM_PORTS-1:0] port_req;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        logic hit_rd;
        logic hit_wr;

        // Address decode for this port's read clear and mask write.
        always_comb begin
            hit_rd = rd_en && (rd_port == PORT_AW'(g));
            hit_wr = en_we && (en_port == PORT_AW'(g));
        end

        port_event_regs #(.EVT_W(EVT_W)) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (evt_pulse[g*EVT_W +: EVT_W]),
            .rd_clr   (hit_rd),
            .en_we    (hit_wr),
            .en_wdata (en_wdata),
            .status   (status_arr[g]),
            .req      (port_req[g])
        );

        assert_other_port_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_port != PORT_AW'(g)) |=>
                ((status_arr[g] & $past(status_arr[g])) == $past(status_arr[g])));
    end

    // Read mux: status of the addressed port.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_PORTS; i++)
            if (rd_port == PORT_AW'(i))
                rd_data = status_arr[i];
    end

    irq_combine #(.NUM_PORTS(NUM_PORTS)) u_comb (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_req  (port_req),
        .glob_en   (glob_en),
        .force_irq (force_irq),
        .irq_n     (irq_n)
    );
endmodule

// File: tb/phy_irq_aggregator_bench.sv
module phy_irq_aggregator_bench;
    localparam int NP = 8;
    localparam int EW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP*EW-1:0] evt_pulse = '0;
    logic          en_we = 1'b0;
    logic [2:0]    en_port = '0;
    logic [EW-1:0] en_wdata = '0;
    logic          glob_en = 1'b0;
    logic          force_irq = 1'b0;
    logic          rd_en = 1'b0;
    logic [2:0]    rd_port = '0;
    logic [EW-1:0] rd_data;
    logic          irq_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    phy_irq_aggregator u_phy_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .en_we(en_we),
        .en_port(en_port), .en_wdata(en_wdata), .glob_en(glob_en),
        .force_irq(force_irq), .rd_en(rd_en), .rd_port(rd_port),
        .rd_data(rd_data), .irq_n(irq_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse(input int p, input int e);
        @(negedge clk);
        evt_pulse = '0;
        evt_pulse[p*EW+e] = 1'b1;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic write_mask(input int p, input logic [EW-1:0] m);
        @(negedge clk);
        en_we = 1'b1; en_port = 3'(p); en_wdata = m;
        @(negedge clk);
        en_we = 1'b0;
    endtask

    // Read and clear one port; compare the returned status.
    task automatic read_port(input int p, input logic [EW-1:0] exp, input string req);
        @(negedge clk);
        rd_en = 1'b1; rd_port = 3'(p);
        #1 check(rd_data == exp, req, rd_data, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(irq_n == 1'b1, "R10 reset irq_n", irq_n, 1);
        check(rd_data == '0, "R1 reset status", rd_data, 0);
        rst_n = 1'b1;

        // R5: masks are zero after reset; all events, global enable on.
        glob_en = 1'b1;
        @(negedge clk);
        evt_pulse = '1;
        @(negedge clk);
        evt_pulse = '0;
        repeat (2) @(negedge clk);
        check(irq_n == 1'b1, "R5 no irq with reset masks", irq_n, 1);
        for (int p = 0; p < NP; p++) read_port(p, 5'h1F, "R1 all events latched");
        for (int p = 0; p < NP; p++) write_mask(p, 5'h1F);

        // R1/R7/R10/R2/R3: sweep every port and event.
        for (int p = 0; p < NP; p++) begin
            for (int e = 0; e < EW; e++) begin
                pulse(p, e);
                check(irq_n == 1'b1, "R10 irq one edge late", irq_n, 1);
                @(negedge clk);
                check(irq_n == 1'b0, "R7 irq from port", irq_n, 0);
                repeat (2) @(negedge clk);
                rd_port = 3'(p);
                #1 check(rd_data == EW'(1 << e), "R2 bit held", rd_data, 1 << e);
                read_port(p, EW'(1 << e), "R3 read value");
                check(rd_data == '0, "R3 cleared by read", rd_data, 0);
                check(irq_n == 1'b0, "R10 irq still low one edge", irq_n, 0);
                @(negedge clk);
                check(irq_n == 1'b1, "R10 irq released", irq_n, 1);
            end
        end

        // R3: event in the same cycle as the read survives.
        pulse(1, 2);
        @(negedge clk);
        rd_en = 1'b1; rd_port = 3'd1; evt_pulse[1*EW+0] = 1'b1;
        #1 check(rd_data == 5'h04, "R3 read before same-cycle event", rd_data, 4);
        @(negedge clk);
        rd_en = 1'b0; evt_pulse = '0;
        check(rd_data == 5'h01, "R3 same-cycle event kept", rd_data, 1);
        read_port(1, 5'h01, "R3 kept bit read");

        // R4: reading one port leaves another port's status.
        pulse(2, 3);
        pulse(5, 4);
        read_port(2, 5'h08, "R4 read port 2");
        repeat (2) @(negedge clk);
        check(irq_n == 1'b0, "R4 other port still requests", irq_n, 0);
        rd_port = 3'd5;
        #1 check(rd_data == 5'h10, "R4 port 5 untouched", rd_data, 16);
        read_port(5, 5'h10, "R4 port 5 read");
        repeat (2) @(negedge clk);

        // R6: mask sweep on port 3, single events.
        for (int m = 0; m < 32; m++) begin
            write_mask(3, 5'(m));
            for (int e = 0; e < EW; e++) begin
                pulse(3, e);
                @(negedge clk);
                check(irq_n == !((m >> e) & 1), "R6 mask gating", irq_n, !((m >> e) & 1));
                read_port(3, EW'(1 << e), "R6 status independent of mask");
                @(negedge clk);
            end
        end

        // R11: mask write to port 4 does not change port 6.
        write_mask(4, 5'h00);
        pulse(6, 0);
        @(negedge clk);
        check(irq_n == 1'b0, "R11 port 6 mask kept", irq_n, 0);
        read_port(6, 5'h01, "R11 clear");
        pulse(4, 0);
        @(negedge clk);
        check(irq_n == 1'b1, "R11 port 4 mask written", irq_n, 1);
        read_port(4, 5'h01, "R11 clear port 4");
        @(negedge clk);

        // R8: global enable gates a pending request.
        glob_en = 1'b0;
        pulse(0, 3);
        repeat (2) @(negedge clk);
        check(irq_n == 1'b1, "R8 gated off", irq_n, 1);
        glob_en = 1'b1;
        @(negedge clk);
        check(irq_n == 1'b0, "R8 enabled passes", irq_n, 0);
        read_port(0, 5'h08, "R8 clear");
        @(negedge clk);

        // R9: force with no events and global enable off.
        glob_en = 1'b0;
        @(negedge clk);
        force_irq = 1'b1;
        @(negedge clk);
        check(irq_n == 1'b0, "R9 forced", irq_n, 0);
        force_irq = 1'b0;
        @(negedge clk);
        check(irq_n == 1'b1, "R9 force released", irq_n, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule